// File: doc/BRIEF.md
# DRAM Retention Test Sequencer

This block measures how long the cells of an attached dynamic memory hold their contents when nobody refreshes them. On a start command it switches off refresh in the memory controller through a refresh-enable output. It then fills every word of the array with a data pattern that holds as many ones as zeros. After the fill it scans the whole array back in the same order. Between two reads it waits a programmable number of idle clock cycles, so that a full scan can last far longer than the nominal 64 ms refresh interval and decayed cells show up as mismatches.

Each word that comes back is compared with the pattern. The block keeps a saturating count of mismatches and records the address and the returned data of the first one. When the scan ends, or when the pass is aborted, refresh is switched back on. A pass can start from any address, because addresses wrap modulo the array size. With the rotate input the next pass moves its start address by a fixed stride and steps to the next of four patterns. This lets repeated passes stress different cells with different data. The block talks to the memory controller over a single-word request/acknowledge port.

Top module: `dram_retention_seq`

## Requirements
- R1: After reset the block is idle: busy, done, mem_req_o and first_err_valid_o are 0, refresh_en_o is 1, err_count_o is 0, and pass_start_o and pass_pattern_o are 0.
- R2: refresh_en_o is 0 from the cycle after a start is accepted until the pass completes or is aborted. It is never 1 while mem_req_o is 1.
- R3: The fill phase writes every one of the 2^ADDR_W addresses exactly once. It goes in ascending order starting at the pass start address and wraps modulo 2^ADDR_W.
- R4: The pattern select chooses a word built by repeating a 4-bit nibble from bit 0 upward: 0 gives 0101 (0x5555 at 16 bits), 1 gives 1010 (0xAAAA), 2 gives 0011 (0x3333), 3 gives 1100 (0xCCCC).
- R5: The scan phase starts only after all writes have been acknowledged. It reads every address exactly once, in the same order as the fill.
- R6: When a read is acknowledged in cycle t and it is not the last one, the next read request first appears in cycle t+W+1, where W is the wait value latched at start. This leaves exactly W idle cycles between reads.
- R7: Once raised, a request holds its address, direction and write data stable until it is acknowledged. Only one request is outstanding at any time.
- R8: Each read word that differs from the pattern adds one to err_count_o. The count saturates at 2^ERR_W-1 and is cleared when a start is accepted.
- R9: The first mismatch of a pass sets first_err_valid_o and captures its address and returned data. Later mismatches in the same pass leave these values unchanged.
- R10: done_o rises when the last read of a pass is acknowledged and is cleared when a start is accepted. An abort while busy returns the block to idle on the next cycle, with done_o left at 0 and refresh_en_o at 1.
- R11: A start with rotate_i = 1 ignores the configuration inputs. It uses the previous pass start plus ROT_STEP (mod 2^ADDR_W) and the previous pattern select plus 1 (mod 4). The start and pattern in use are shown on pass_start_o and pass_pattern_o.
- R12: A start pulse while a pass is busy is ignored. The running pass keeps its start address, pattern and pacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a pass when idle |
| abort_i | input | 1 | Abandon the running pass |
| rotate_i | input | 1 | Derive start address and pattern from the previous pass |
| cfg_start_addr_i | input | ADDR_W | Start address when not rotating |
| cfg_pattern_i | input | 2 | Pattern select when not rotating |
| cfg_wait_i | input | WAIT_W | Idle cycles between reads |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ADDR_W | Access address |
| mem_wdata_o | output | DATA_W | Write data |
| mem_ack_i | input | 1 | Access accepted; read data valid in the same cycle |
| mem_rdata_i | input | DATA_W | Read data |
| refresh_en_o | output | 1 | Refresh enable toward the controller |
| busy_o | output | 1 | Pass in progress |
| done_o | output | 1 | Last pass completed |
| pass_start_o | output | ADDR_W | Start address of the current or last pass |
| pass_pattern_o | output | 2 | Pattern select of the current or last pass |
| err_count_o | output | ERR_W | Saturating mismatch count |
| first_err_valid_o | output | 1 | A mismatch has been recorded this pass |
| first_err_addr_o | output | ADDR_W | Address of the first mismatch |
| first_err_data_o | output | DATA_W | Data returned at the first mismatch |

## Verification
The block is driven by a memory model with random acknowledge latency. The model can corrupt chosen addresses on readback. Directed passes cover a clean scan from address 0 with no pacing, a wrapped scan with pacing in which one corrupt address lies before the wrap point and one after it, and an error storm that drives the count to saturation. Together these separate the wrap order, the choice of the first mismatch, and the saturation behaviour. Rotated starts, including the step from pattern 3 back to 0, an abort in mid-scan, a start pulse during a busy pass, and seeded random passes with random corruption check pass chaining and the rules on when input is ignored.

// File: rtl/rts_pkg.sv
package rts_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_SCAN  = 2'd2,
        ST_PAUSE = 2'd3
    } seq_state_e;

    localparam int MAX_DATA_W = 64;

    function automatic logic [3:0] pattern_nibble(input logic [1:0] sel);
        case (sel)
            2'd0:    return 4'b0101;
            2'd1:    return 4'b1010;
            2'd2:    return 4'b0011;
            default: return 4'b1100;
        endcase
    endfunction

    function automatic logic [MAX_DATA_W-1:0] pattern_word(input logic [1:0] sel);
        logic [3:0] nib;
        logic [MAX_DATA_W-1:0] w;
        nib = pattern_nibble(sel);
        for (int i = 0; i < MAX_DATA_W; i++) begin
            w[i] = nib[i % 4];
        end
        return w;
    endfunction

endpackage

// File: rtl/rts_walker.sv
module rts_walker #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              step,
    input  logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    localparam logic [ADDR_W-1:0] IDX_MAX = {ADDR_W{1'b1}};

    logic [ADDR_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            idx_q <= '0;
        end else if (step) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    always_comb begin
        addr = base + idx_q;
        last = (idx_q == IDX_MAX);
    end
endmodule

// File: rtl/rts_pacer.sv
module rts_pacer #(
    parameter int WAIT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WAIT_W-1:0] load_val,
    input  logic              dec,
    output logic              hit
);
    logic [WAIT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign hit = (cnt_q == {{(WAIT_W-1){1'b0}}, 1'b1});
endmodule

// File: rtl/rts_err_log.sv
module rts_err_log #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16,
    parameter int ERR_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              check,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] expected,
    output logic [ERR_W-1:0]  err_count,
    output logic              first_valid,
    output logic [ADDR_W-1:0] first_addr,
    output logic [DATA_W-1:0] first_data
);
    localparam logic [ERR_W-1:0] ERR_MAX = {ERR_W{1'b1}};

    logic mismatch;
    assign mismatch = check && (rdata != expected);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            err_count   <= '0;
            first_valid <= 1'b0;
            first_addr  <= '0;
            first_data  <= '0;
        end else if (mismatch) begin
            if (err_count != ERR_MAX) begin
                err_count <= err_count + 1'b1;
            end
            if (!first_valid) begin
                first_valid <= 1'b1;
                first_addr  <= addr;
                first_data  <= rdata;
            end
        end
    end
endmodule

// File: rtl/dram_retention_seq.sv
module dram_retention_seq
    import rts_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int DATA_W   = 16,
    parameter int WAIT_W   = 32,
    parameter int ERR_W    = 32,
    parameter int ROT_STEP = 37
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              abort_i,
    input  logic              rotate_i,
    input  logic [ADDR_W-1:0] cfg_start_addr_i,
    input  logic [1:0]        cfg_pattern_i,
    input  logic [WAIT_W-1:0] cfg_wait_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic              mem_ack_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              refresh_en_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [ADDR_W-1:0] pass_start_o,
    output logic [1:0]        pass_pattern_o,
    output logic [ERR_W-1:0]  err_count_o,
    output logic              first_err_valid_o,
    output logic [ADDR_W-1:0] first_err_addr_o,
    output logic [DATA_W-1:0] first_err_data_o
);
    localparam logic [ADDR_W-1:0] ROT_INC = ADDR_W'(ROT_STEP);

    seq_state_e        state_q;
    logic [ADDR_W-1:0] pass_start_q;
    logic [1:0]        pass_sel_q;
    logic [WAIT_W-1:0] wait_q;
    logic              done_q;

    logic              start_acc;
    logic              fire;
    logic              wr_fire;
    logic              rd_fire;
    logic              walk_last;
    logic              walk_clear;
    logic              walk_step;
    logic              pace_hit;
    logic [ADDR_W-1:0] walk_addr;
    logic [ADDR_W-1:0] next_start;
    logic [1:0]        next_sel;
    logic [MAX_DATA_W-1:0] pat_full;
    logic [DATA_W-1:0] pat_word;

    always_comb begin
        busy_o     = (state_q != ST_IDLE);
        mem_req_o  = (state_q == ST_FILL) || (state_q == ST_SCAN);
        mem_we_o   = (state_q == ST_FILL);
        start_acc  = (state_q == ST_IDLE) && start_i;
        fire       = mem_req_o && mem_ack_i && !abort_i;
        wr_fire    = fire && mem_we_o;
        rd_fire    = fire && !mem_we_o;
        walk_clear = start_acc || (wr_fire && walk_last);
        walk_step  = fire && !walk_last;
        next_start = rotate_i ? pass_start_q + ROT_INC : cfg_start_addr_i;
        next_sel   = rotate_i ? pass_sel_q + 2'd1 : cfg_pattern_i;
        pat_full   = pattern_word(pass_sel_q);
        pat_word   = pat_full[DATA_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            pass_start_q <= '0;
            pass_sel_q   <= '0;
            wait_q       <= '0;
            done_q       <= 1'b0;
        end else if (state_q == ST_IDLE) begin
            if (start_i) begin
                state_q      <= ST_FILL;
                pass_start_q <= next_start;
                pass_sel_q   <= next_sel;
                wait_q       <= cfg_wait_i;
                done_q       <= 1'b0;
            end
        end else if (abort_i) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_FILL: begin
                    if (wr_fire && walk_last) begin
                        state_q <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (rd_fire) begin
                        if (walk_last) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else if (wait_q != '0) begin
                            state_q <= ST_PAUSE;
                        end
                    end
                end
                ST_PAUSE: begin
                    if (pace_hit) begin
                        state_q <= ST_SCAN;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    rts_walker #(.ADDR_W(ADDR_W)) u_walker (
        .clk   (clk),
        .rst   (rst),
        .clear (walk_clear),
        .step  (walk_step),
        .base  (pass_start_q),
        .addr  (walk_addr),
        .last  (walk_last)
    );

    rts_pacer #(.WAIT_W(WAIT_W)) u_pacer (
        .clk      (clk),
        .rst      (rst),
        .load     (rd_fire && !walk_last),
        .load_val (wait_q),
        .dec      (state_q == ST_PAUSE),
        .hit      (pace_hit)
    );

    rts_err_log #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ERR_W(ERR_W)) u_log (
        .clk         (clk),
        .rst         (rst),
        .clear       (start_acc),
        .check       (rd_fire),
        .addr        (walk_addr),
        .rdata       (mem_rdata_i),
        .expected    (pat_word),
        .err_count   (err_count_o),
        .first_valid (first_err_valid_o),
        .first_addr  (first_err_addr_o),
        .first_data  (first_err_data_o)
    );

    assign mem_addr_o     = walk_addr;
    assign mem_wdata_o    = pat_word;
    assign refresh_en_o   = !busy_o;
    assign done_o         = done_q;
    assign pass_start_o   = pass_start_q;
    assign pass_pattern_o = pass_sel_q;
endmodule

// File: rtl/dram_retention_seq_sva.sv
module dram_retention_seq_sva #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16,
    parameter int ERR_W  = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              abort_i,
    input logic              start_i,
    input logic              mem_req_o,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [DATA_W-1:0] mem_wdata_o,
    input logic              mem_ack_i,
    input logic              refresh_en_o,
    input logic              busy_o,
    input logic              done_o,
    input logic [ERR_W-1:0]  err_count_o,
    input logic              first_err_valid_o,
    input logic [ADDR_W-1:0] first_err_addr_o,
    input logic [DATA_W-1:0] first_err_data_o
);
    localparam logic [ERR_W-1:0] ERR_MAX = {ERR_W{1'b1}};

    p_refresh_off_r2: assert property (@(posedge clk) disable iff (rst)
        mem_req_o |-> !refresh_en_o);

    p_hold_req_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && !mem_ack_i && !abort_i) |=>
        (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));

    p_err_sat_r8: assert property (@(posedge clk) disable iff (rst)
        (busy_o && err_count_o == ERR_MAX) |=> (err_count_o == ERR_MAX));

    p_first_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (busy_o && first_err_valid_o) |=>
        (first_err_valid_o && $stable(first_err_addr_o) && $stable(first_err_data_o)));

    p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    p_abort_r10: assert property (@(posedge clk) disable iff (rst)
        (busy_o && abort_i) |=> (!busy_o && refresh_en_o && !done_o));

    p_start_busy_r12: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i && !abort_i) |=> !done_o || !busy_o);
endmodule

bind dram_retention_seq dram_retention_seq_sva #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ERR_W(ERR_W)
) u_sva (
    .clk               (clk),
    .rst               (rst),
    .abort_i           (abort_i),
    .start_i           (start_i),
    .mem_req_o         (mem_req_o),
    .mem_we_o          (mem_we_o),
    .mem_addr_o        (mem_addr_o),
    .mem_wdata_o       (mem_wdata_o),
    .mem_ack_i         (mem_ack_i),
    .refresh_en_o      (refresh_en_o),
    .busy_o            (busy_o),
    .done_o            (done_o),
    .err_count_o       (err_count_o),
    .first_err_valid_o (first_err_valid_o),
    .first_err_addr_o  (first_err_addr_o),
    .first_err_data_o  (first_err_data_o)
);

// File: tb/dram_retention_seq_tb.sv
module dram_retention_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 16;
    localparam int WAIT_W = 32;
    localparam int ERR_W  = 4;
    localparam int ROT    = 7;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int ERR_MAX = (1 << ERR_W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0, abort_i = 1'b0, rotate_i = 1'b0;
    logic [ADDR_W-1:0] cfg_start_addr_i = '0;
    logic [1:0] cfg_pattern_i = '0;
    logic [WAIT_W-1:0] cfg_wait_i = '0;
    logic mem_req_o, mem_we_o, mem_ack_i = 1'b0;
    logic [ADDR_W-1:0] mem_addr_o;
    logic [DATA_W-1:0] mem_wdata_o, mem_rdata_i = '0;
    logic refresh_en_o, busy_o, done_o, first_err_valid_o;
    logic [ADDR_W-1:0] pass_start_o, first_err_addr_o;
    logic [1:0] pass_pattern_o;
    logic [ERR_W-1:0] err_count_o;
    logic [DATA_W-1:0] first_err_data_o;

    dram_retention_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W),
                         .ERR_W(ERR_W), .ROT_STEP(ROT)) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .abort_i(abort_i), .rotate_i(rotate_i),
        .cfg_start_addr_i(cfg_start_addr_i), .cfg_pattern_i(cfg_pattern_i),
        .cfg_wait_i(cfg_wait_i), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i),
        .mem_rdata_i(mem_rdata_i), .refresh_en_o(refresh_en_o), .busy_o(busy_o),
        .done_o(done_o), .pass_start_o(pass_start_o), .pass_pattern_o(pass_pattern_o),
        .err_count_o(err_count_o), .first_err_valid_o(first_err_valid_o),
        .first_err_addr_o(first_err_addr_o), .first_err_data_o(first_err_data_o));

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, errors = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // memory model and monitor state
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] flip [DEPTH];
    int lat = 0;
    int exp_start = 0, exp_sel = 0, exp_wait = 0;
    int wr_k = 0, rd_k = 0, ack_cyc = 0, mon_bad = 0;
    bit rd_pend = 0;
    int gap_bad = 0, order_bad = 0, pat_bad = 0, rf_bad = 0;

    function automatic logic [DATA_W-1:0] pat(input int sel);
        logic [3:0] nib;
        logic [DATA_W-1:0] w;
        case (sel)
            0: nib = 4'b0101;
            1: nib = 4'b1010;
            2: nib = 4'b0011;
            default: nib = 4'b1100;
        endcase
        for (int i = 0; i < DATA_W; i++) w[i] = nib[i % 4];
        return w;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (mem_req_o && refresh_en_o) rf_bad++;
            if (mem_req_o && !mem_we_o && !rd_pend) begin
                rd_pend = 1;
                if (rd_k > 0 && (cyc - ack_cyc) != exp_wait + 1) gap_bad++;
            end
            if (mem_ack_i) begin
                mem_ack_i <= 1'b0;
            end else if (mem_req_o) begin
                if (lat == 0) begin
                    mem_ack_i <= 1'b1;
                    lat = $urandom % 3;
                    if (mem_we_o) begin
                        if (int'(mem_addr_o) != (exp_start + wr_k) % DEPTH || rd_k != 0) order_bad++;
                        if (mem_wdata_o != pat(exp_sel)) pat_bad++;
                        mem[mem_addr_o] = mem_wdata_o;
                        wr_k++;
                    end else begin
                        if (int'(mem_addr_o) != (exp_start + rd_k) % DEPTH || wr_k != DEPTH) order_bad++;
                        mem_rdata_i <= mem[mem_addr_o] ^ flip[mem_addr_o];
                        rd_k++;
                        rd_pend = 0;
                        ack_cyc = cyc;
                    end
                end else begin
                    lat--;
                end
            end
        end
    end

    int prev_start = 0, prev_sel = 0;

    task automatic clear_flips();
        for (int a = 0; a < DEPTH; a++) flip[a] = '0;
    endtask

    task automatic wait_idle();
        int t = 0;
        while (busy_o && t < 20000) begin @(negedge clk); t++; end
        check(!busy_o, "R10 pass terminates", busy_o, 0);
    endtask

    task automatic launch(input int st, input int sel, input int w, input bit rot);
        @(negedge clk);
        if (rot) begin
            exp_start = (prev_start + ROT) % DEPTH;
            exp_sel = (prev_sel + 1) % 4;
        end else begin
            exp_start = st; exp_sel = sel;
        end
        exp_wait = w; wr_k = 0; rd_k = 0; rd_pend = 0;
        gap_bad = 0; order_bad = 0; pat_bad = 0; rf_bad = 0;
        cfg_start_addr_i = ADDR_W'(st); cfg_pattern_i = 2'(sel);
        cfg_wait_i = WAIT_W'(w); rotate_i = rot; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; rotate_i = 1'b0;
        prev_start = exp_start; prev_sel = exp_sel;
        check(busy_o && !refresh_en_o, "R2 refresh off when pass starts", refresh_en_o, 0);
    endtask

    task automatic finish_pass();
        int nerr = 0, fa = -1, k;
        wait_idle();
        for (k = 0; k < DEPTH; k++) begin
            int a = (exp_start + k) % DEPTH;
            if (flip[a] != 0) begin
                nerr++;
                if (fa < 0) fa = a;
            end
        end
        check(done_o && refresh_en_o, "R10 done and refresh restored", done_o, 1);
        check(wr_k == DEPTH && order_bad == 0, "R3 R5 fill/scan order and coverage", order_bad, 0);
        check(rd_k == DEPTH, "R5 scan covers every address once", rd_k, DEPTH);
        check(pat_bad == 0, "R4 write data equals selected pattern", pat_bad, 0);
        check(gap_bad == 0, "R6 read pacing gap", gap_bad, 0);
        check(rf_bad == 0, "R2 refresh off during accesses", rf_bad, 0);
        check(int'(pass_start_o) == exp_start && int'(pass_pattern_o) == exp_sel,
              "R11 pass start and pattern", pass_start_o, exp_start);
        check(int'(err_count_o) == ((nerr > ERR_MAX) ? ERR_MAX : nerr),
              "R8 error count", err_count_o, (nerr > ERR_MAX) ? ERR_MAX : nerr);
        check(first_err_valid_o == (nerr > 0), "R9 first mismatch valid", first_err_valid_o, nerr > 0);
        if (nerr > 0) begin
            check(int'(first_err_addr_o) == fa, "R9 first mismatch address", first_err_addr_o, fa);
            check(first_err_data_o == (pat(exp_sel) ^ flip[fa]), "R9 first mismatch data",
                  first_err_data_o, pat(exp_sel) ^ flip[fa]);
        end
    endtask

    initial begin
        int t;
        void'($urandom(32'd4242));
        clear_flips();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!busy_o && !done_o && !mem_req_o && refresh_en_o, "R1 idle after reset", busy_o, 0);
        check(err_count_o == 0 && !first_err_valid_o && pass_start_o == 0 && pass_pattern_o == 0,
              "R1 status cleared", err_count_o, 0);

        // clean pass, no pacing
        launch(0, 0, 0, 0);
        finish_pass();

        // wrapped pass with pacing; corruption before and after wrap
        flip[20] = 16'h0001; flip[3] = 16'h0100;
        launch(13, 2, 3, 0);
        finish_pass();

        // R12: start pulse while busy is ignored
        clear_flips();
        flip[9] = 16'h8000;
        launch(25, 1, 2, 0);
        repeat (40) @(negedge clk);
        cfg_start_addr_i = 5'd0; cfg_pattern_i = 2'd3; cfg_wait_i = 0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(int'(pass_start_o) == 25 && pass_pattern_o == 2'd1, "R12 busy start ignored",
              pass_start_o, 25);
        finish_pass();

        // R11 rotate: 25+7 -> 0, pattern 1 -> 2
        clear_flips();
        launch(0, 0, 1, 1);
        finish_pass();
        launch(0, 0, 0, 1);   // pattern 3
        finish_pass();
        launch(0, 0, 0, 1);   // pattern wraps to 0
        check(pass_pattern_o == 2'd0, "R11 pattern wraps 3 to 0", pass_pattern_o, 0);
        finish_pass();

        // R8 saturation
        for (int a = 0; a < 20; a++) flip[a] = 16'h0010;
        launch(4, 3, 0, 0);
        finish_pass();
        clear_flips();

        // R10 abort in mid-scan
        launch(6, 1, 4, 0);
        t = 0;
        while (!(mem_req_o && !mem_we_o && rd_k > 3) && t < 5000) begin @(negedge clk); t++; end
        abort_i = 1'b1;
        @(negedge clk);
        abort_i = 1'b0;
        check(!busy_o && refresh_en_o && !mem_req_o && !done_o, "R10 abort returns idle",
              busy_o, 0);
        repeat (3) @(negedge clk);

        // random passes
        for (int p = 0; p < 6; p++) begin
            clear_flips();
            for (int a = 0; a < DEPTH; a++)
                if ($urandom % 6 == 0) flip[a] = DATA_W'(1 << ($urandom % DATA_W));
            launch($urandom % DEPTH, $urandom % 4, $urandom % 5, ($urandom % 3) == 0);
            finish_pass();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule